// File: doc/BRIEF.md
# Quality-of-Service SRAM Port Arbiter

This block lets several requesters share a single-ported SRAM. Every cycle it looks at the pending requests, ranks them by a 2-bit service level held per port, and breaks ties by taking the port with the smallest index. It grants exactly one of them. The chosen port's address, write enable and write data drive the SRAM side, and the read data comes back on the SRAM's registered output.

Service levels are encoded as 0 = background, 1 = bandwidth-sensitive, 2 = latency-sensitive and 3 = critical. A port at level 0 or 1 must wait through one extra cycle before it can win a grant. A port at level 2 or 3 can be granted in the cycle its request first appears. The levels sit in per-port registers reached over a 32-bit configuration port. Some ports are tied to a fixed level by parameter. By default, port 0 carries the processor traffic and is fixed at 3.

Top module: `qos_sram_arb`

## Requirements
- R1: After reset the levels are 3, 3, 2, 2 for ports 0 to 3, and no grant is issued while no request is present.
- R2: Among eligible requests, the port with the highest level is granted.
- R3: Among eligible requests at the same level, the port with the lowest index is granted.
- R4: A request from a port at level 0 or 1 is not granted in the first cycle it is pending. Here "pending" counts from when the request rises, or from the cycle after that port's previous grant. The request becomes eligible from its second pending cycle onward.
- R5: A request from a port at level 2 or 3 with no competitor is granted in the cycle it is first presented.
- R6: At most one port is granted per cycle, and only a port that is requesting.
- R7: A granted read (write enable 0) raises that port's read-valid bit exactly one cycle after the grant, with the SRAM word at the requested address on its read-data slice. A granted write raises no read-valid.
- R8: A configuration write with all four byte enables set stores wdata[1:0] as the selected port's level, effective from the next cycle. A configuration read returns the level in bits [1:0] and zeros above.
- R9: A configuration write with any byte enable clear is ignored.
- R10: A port fixed by parameter (port 0 by default) always reads back level 3, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORT | Access request per port |
| addr | input | NPORT*AW | Address per port, port i at [i*AW +: AW] |
| we | input | NPORT | Write enable per port |
| wdata | input | NPORT*DW | Write data per port |
| gnt | output | NPORT | One-hot grant in the current cycle |
| rvalid | output | NPORT | Read data valid, one cycle after a read grant |
| rdata | output | NPORT*DW | Read data per port |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, registered one cycle after access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | PW | Port whose level is accessed |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Level of the selected port |

## Verification
The assertions assume that a requester keeps its request, address, write enable and write data steady until it is granted. They also assume the SRAM returns read data one cycle after an access, and that at most one configuration write arrives per cycle. The bench's random requesters follow these rules: a request is raised with fixed attributes and dropped only once its grant has been seen. The bench's SRAM model is a registered-read array. Level changes arrive at random, with partial byte enables and writes to the fixed port mixed in.

// File: rtl/qos_sram_arb.sv
module qos_sram_arb #(
  parameter int NPORT = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [2*NPORT-1:0] RST_LVL = 8'b10_10_11_11,
  parameter logic [NPORT-1:0] FIXED = 4'b0001,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req,
  input  logic [NPORT*AW-1:0] addr,
  input  logic [NPORT-1:0]    we,
  input  logic [NPORT*DW-1:0] wdata,
  output logic [NPORT-1:0]    gnt,
  output logic [NPORT-1:0]    rvalid,
  output logic [NPORT*DW-1:0] rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                cfg_we,
  input  logic [PW-1:0]       cfg_sel,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata
);

  logic [1:0]         lvl [NPORT];
  logic [2*NPORT-1:0] lvl_flat;
  logic [NPORT-1:0]   waited_q;
  logic [NPORT-1:0]   elig;
  logic [PW-1:0]      sel;
  logic [1:0]         best;
  logic               any;
  logic               full_wr;

  assign full_wr = cfg_we && (cfg_be == 4'hF);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    if (FIXED[i]) begin : g_fixed
      assign lvl[i] = 2'd3;
    end else begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rst_n) lvl[i] <= RST_LVL[2*i +: 2];
        else if (full_wr && cfg_sel == PW'(i)) lvl[i] <= cfg_wdata[1:0];
      end
    end
    assign lvl_flat[2*i +: 2] = lvl[i];
    assign elig[i] = req[i] & (lvl[i][1] | waited_q[i]);
  end

  always_comb begin
    any = 1'b0;
    best = 2'd0;
    sel = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (elig[i] && (!any || lvl[i] > best)) begin
        any = 1'b1;
        best = lvl[i];
        sel = PW'(i);
      end
    end
  end

  assign gnt       = any ? (NPORT'(1) << sel) : '0;
  assign mem_en    = any;
  assign mem_we    = any & we[sel];
  assign mem_addr  = addr[sel*AW +: AW];
  assign mem_wdata = wdata[sel*DW +: DW];
  assign rdata     = {NPORT{mem_rdata}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waited_q <= '0;
      rvalid   <= '0;
    end else begin
      waited_q <= req & ~gnt;
      rvalid   <= gnt & ~we;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NPORT; i++)
      if (cfg_sel == PW'(i)) cfg_rdata[1:0] = lvl[i];
  end

endmodule

// File: rtl/qos_sram_arb_chk.sv
module qos_sram_arb_chk #(
  parameter int NPORT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT-1:0]   req,
  input logic [NPORT-1:0]   we,
  input logic [NPORT-1:0]   gnt,
  input logic [NPORT-1:0]   rvalid,
  input logic [2*NPORT-1:0] lvl_flat,
  input logic               cfg_we,
  input logic [3:0]         cfg_be
);

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & ~we)) |=> (rvalid == $past(gnt & ~we)));

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(gnt & ~we)) |=> (rvalid == '0));

  a_r9_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be != 4'hF) |=> $stable(lvl_flat));

  for (genvar i = 0; i < NPORT; i++) begin : g_low
    a_r4_low_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && !lvl_flat[2*i+1]) |-> $past(req[i] && !gnt[i]));
  end

endmodule

bind qos_sram_arb qos_sram_arb_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .gnt(gnt),
  .rvalid(rvalid), .lvl_flat(lvl_flat), .cfg_we(cfg_we), .cfg_be(cfg_be)
);

// File: tb/qos_sram_arb_test.sv
`timescale 1ns/1ps
module qos_sram_arb_test;
  localparam int N = 4, AW = 8, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0] gnt, rvalid;
  logic [N*DW-1:0] rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rd;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;

  always #2.5 clk = ~clk;

  qos_sram_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .wdata(wdata),
    .gnt(gnt), .rvalid(rvalid), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rd),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  logic [DW-1:0] sram [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) sram[i] <= '0;
      mem_rd <= '0;
    end else if (mem_en) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else mem_rd <= sram[mem_addr];
    end
  end

  int errors = 0, checks = 0;
  logic [DW-1:0] shadow [256];
  logic [1:0] mq [N];
  logic [N-1:0] mwait = '0, exp_rv = '0;
  logic [DW-1:0] exp_rd = '0;
  logic done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_gnt();
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < N; i++)
        if (req[i] && mq[i] == 2'(l) && (l >= 2 || mwait[i]))
          return N'(1) << i;
    return '0;
  endfunction

  task automatic do_cycle(string tag);
    logic [N-1:0] eg;
    #1;
    eg = exp_gnt();
    chk(tag, 32'(gnt), 32'(eg));
    chk("R7", 32'(rvalid), 32'(exp_rv));
    for (int i = 0; i < N; i++)
      if (exp_rv[i]) chk("R7", rdata[i*DW +: DW], exp_rd);
    @(posedge clk);
    mwait = req & ~eg;
    exp_rv = eg & ~we;
    for (int i = 0; i < N; i++)
      if (eg[i]) begin
        if (we[i]) shadow[addr[i*AW +: AW]] = wdata[i*DW +: DW];
        else exp_rd = shadow[addr[i*AW +: AW]];
      end
    if (cfg_we && cfg_be == 4'hF && cfg_sel != 2'd0) mq[cfg_sel] = cfg_wdata[1:0];
    #1;
    req = req & ~eg;
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic cfg_write(int p, logic [3:0] be, logic [31:0] d);
    cfg_we = 1; cfg_sel = 2'(p); cfg_be = be; cfg_wdata = d;
    do_cycle("R6");
  endtask

  task automatic set_port(int p, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    req[p] = 1; we[p] = w; addr[p*AW +: AW] = a; wdata[p*DW +: DW] = d;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    mq[0] = 3; mq[1] = 3; mq[2] = 2; mq[3] = 2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset levels and idle grant
    for (int p = 0; p < N; p++) begin
      cfg_sel = 2'(p); #1;
      chk("R1", cfg_rdata, 32'(mq[p]));
    end
    chk("R1", 32'(gnt), 0);
    do_cycle("R1");
    // R8 full write, upper read bits zero
    cfg_write(3, 4'hF, 32'hFFFF_FFFC);
    cfg_sel = 2'd3; #0.5; chk("R8", cfg_rdata, 32'h0);
    // R9 partial write ignored
    cfg_write(3, 4'h3, 32'h3);
    cfg_sel = 2'd3; #0.5; chk("R9", cfg_rdata, 32'h0);
    // R10 fixed port
    cfg_write(0, 4'hF, 32'h1);
    cfg_sel = 2'd0; #0.5; chk("R10", cfg_rdata, 32'h3);
    // R4 low level waits one cycle
    set_port(3, 1, 8'h10, 32'h1111_2222);
    do_cycle("R4");
    do_cycle("R4");
    chk("R4", 32'(req), 0);
    // R5 level 2 granted at once; R7 write then read
    set_port(2, 1, 8'h05, 32'hDEAD_BEEF);
    do_cycle("R5");
    set_port(2, 0, 8'h05, 32'h0);
    do_cycle("R5");
    #0.5; chk("R7", 32'(rvalid), 32'h4); chk("R7", rdata[2*DW +: DW], 32'hDEAD_BEEF);
    do_cycle("R7");
    // R2 higher level wins
    set_port(1, 0, 8'h05, 0); set_port(2, 0, 8'h10, 0);
    do_cycle("R2");
    do_cycle("R2");
    // R3 tie goes to lowest index
    set_port(0, 0, 8'h10, 0); set_port(1, 1, 8'h20, 32'h5);
    do_cycle("R3");
    do_cycle("R3");
    // random phase
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < N; p++)
        if (!req[p] && ($urandom % 3 == 0))
          set_port(p, 1'($urandom), 8'($urandom % 32), $urandom);
      if ($urandom % 8 == 0) begin
        cfg_we = 1; cfg_sel = 2'($urandom); cfg_wdata = $urandom;
        case ($urandom % 4)
          0: cfg_be = 4'h3;
          1: cfg_be = 4'hC;
          default: cfg_be = 4'hF;
        endcase
      end
      do_cycle("R2/R3/R4/R6");
    end
    for (int p = 0; p < N; p++) begin
      cfg_sel = 2'(p); #0.5;
      chk(p == 0 ? "R10" : "R8", cfg_rdata, 32'(mq[p]));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule